// File: doc/BRIEF.md
# PTP Offset and Mean Path Delay Calculator

This block takes the four timestamps of a single delay request-response exchange between a time master and a time slave and turns them into two signed results: how far the slave clock sits ahead of the master clock (offset), and the average one-way transit time across the link (mean delay). Each timestamp arrives on one shared input with a 2-bit tag that says which of the four event times it carries. The block accepts them only in exchange order. When the last one is taken, it registers both results and pulses `done` for one cycle.

The arithmetic assumes the link is equally fast in both directions. The forward leg is `fwd = t2 - t1`, the slave's receive time of Sync minus the master's send time of Sync; the master's send time reaches the slave later in a follow-up message. The return leg is `rev = t4 - t3`, the master's receive time of the delay request minus the slave's send time of that request; the master's receive time comes back in the delay response. The mean delay is half of `fwd + rev` and the offset is half of `fwd - rev`. Each halving is an arithmetic shift right, so results round toward negative infinity. A negative mean delay means the exchange is not physically consistent. For such an exchange the block raises an error flag and keeps the previous offset.

A finite-state machine steps through four named states. `ST_WAIT_T1` waits for the master Sync send time. `ST_WAIT_T2` waits for the slave Sync receive time. `ST_WAIT_T3` waits for the slave delay-request send time. `ST_WAIT_T4` waits for the master delay-request receive time. The transitions are:

- `ACCEPT_T1` moves from `ST_WAIT_T1` to `ST_WAIT_T2`.
- `ACCEPT_T2` moves from `ST_WAIT_T2` to `ST_WAIT_T3`.
- `ACCEPT_T3` moves from `ST_WAIT_T3` to `ST_WAIT_T4`.
- `FINISH` moves from `ST_WAIT_T4` back to `ST_WAIT_T1` and fires the computation.
- `RESTART` is a tag-0 timestamp in `ST_WAIT_T2`, `ST_WAIT_T3` or `ST_WAIT_T4`. It stores the new t1 and moves to `ST_WAIT_T2`.
- `HOLD` covers every other input, which leaves the state unchanged.

Top module: `ptp_offset_delay_calc`

## Requirements
- R1: While reset is asserted (active-low `rst_n`) and in the first cycle after it, `done`, `delay_err`, `offset` and `mean_delay` are all zero.
- R2: `ts_tag` encodes 0 = master Sync send time (t1), 1 = slave Sync receive time (t2), 2 = slave delay-request send time (t3), 3 = master delay-request receive time (t4). A valid timestamp whose tag is neither the next one expected nor 0 is ignored and changes no result.
- R3: `done` is high for exactly one cycle: the cycle after the clock edge that accepts t4.
- R4: On `done`, `mean_delay` equals floor(((t2 - t1) + (t4 - t3)) / 2), computed as signed values.
- R5: On `done` after a non-negative mean delay, `offset` equals floor(((t2 - t1) - (t4 - t3)) / 2), computed as signed values.
- R6: A valid tag-0 timestamp that arrives before t4 discards the partial set. Collection restarts with it as the new t1.
- R7: When the computed mean delay is negative, `delay_err` is 1 and `offset` keeps its previous value, while `mean_delay` takes the negative value. The next exchange with a non-negative mean delay clears `delay_err`.
- R8: Between `done` pulses, `offset`, `mean_delay` and `delay_err` hold their values.
- R9: While `ts_valid` is low, `ts_tag` and `ts_value` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ts_valid | input | 1 | Timestamp on `ts_value` is present this cycle |
| ts_tag | input | 2 | Which exchange event the timestamp belongs to (R2 encoding) |
| ts_value | input | TS_W | Signed nanosecond timestamp |
| done | output | 1 | One-cycle strobe: new results are available |
| offset | output | TS_W | Signed slave-minus-master offset in ns |
| mean_delay | output | TS_W | Signed mean one-way path delay in ns |
| delay_err | output | 1 | Last exchange produced a negative mean delay |

## Verification
The bench builds the block with its default `TS_W = 64`. At that width, timestamps near 1.2e18 ns (calendar-epoch scale) can be driven, so the extra guard bits in the subtractions are exercised with realistic magnitudes next to small hand-checkable values. Odd sums and differences of both signs reach the floor-rounding corner. Restarts, out-of-order tags and idle-cycle garbage reach every `RESTART` and `HOLD` transition of the state machine.

// File: rtl/ptp_calc_pkg.sv
package ptp_calc_pkg;

    // Tag codes carried on ts_tag; the order is the exchange order.
    typedef enum logic [1:0] {
        TAG_T1 = 2'd0,
        TAG_T2 = 2'd1,
        TAG_T3 = 2'd2,
        TAG_T4 = 2'd3
    } ts_tag_e;

    // Collection states: each names the timestamp awaited.
    typedef enum logic [1:0] {
        ST_WAIT_T1 = 2'd0,
        ST_WAIT_T2 = 2'd1,
        ST_WAIT_T3 = 2'd2,
        ST_WAIT_T4 = 2'd3
    } calc_state_e;

    // Number of timestamps held in storage before the final one arrives.
    localparam int unsigned HELD_TS = 3;

endpackage

// File: rtl/ptp_calc_fsm.sv
module ptp_calc_fsm
    import ptp_calc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ts_valid,
    input  logic [1:0]          ts_tag,
    output logic [HELD_TS-1:0]  load,
    output logic                fire
);

    calc_state_e state_q;
    calc_state_e state_d;

    logic is_t1;
    logic is_t2;
    logic is_t3;
    logic is_t4;

    always_comb begin
        is_t1 = ts_valid && (ts_tag == TAG_T1);
        is_t2 = ts_valid && (ts_tag == TAG_T2);
        is_t3 = ts_valid && (ts_tag == TAG_T3);
        is_t4 = ts_valid && (ts_tag == TAG_T4);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_T1;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_T1: begin
                if (is_t1) state_d = ST_WAIT_T2;           // ACCEPT_T1
            end
            ST_WAIT_T2: begin
                if (is_t1)      state_d = ST_WAIT_T2;      // RESTART
                else if (is_t2) state_d = ST_WAIT_T3;      // ACCEPT_T2
            end
            ST_WAIT_T3: begin
                if (is_t1)      state_d = ST_WAIT_T2;      // RESTART
                else if (is_t3) state_d = ST_WAIT_T4;      // ACCEPT_T3
            end
            ST_WAIT_T4: begin
                if (is_t1)      state_d = ST_WAIT_T2;      // RESTART
                else if (is_t4) state_d = ST_WAIT_T1;      // FINISH
            end
        endcase
    end

    // Strobes for storage and the result stage
    always_comb begin
        load    = '0;
        fire    = 1'b0;
        load[0] = is_t1;
        unique case (state_q)
            ST_WAIT_T1: ;
            ST_WAIT_T2: load[1] = is_t2;
            ST_WAIT_T3: load[2] = is_t3;
            ST_WAIT_T4: fire    = is_t4;
        endcase
    end

endmodule

// File: rtl/ptp_ts_store.sv
module ptp_ts_store
    import ptp_calc_pkg::*;
#(
    parameter int unsigned TS_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [HELD_TS-1:0]  load,
    input  logic [TS_W-1:0]     ts_value,
    output logic [TS_W-1:0]     t1,
    output logic [TS_W-1:0]     t2,
    output logic [TS_W-1:0]     t3
);

    logic [HELD_TS-1:0][TS_W-1:0] slot_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            for (int i = 0; i < HELD_TS; i++) begin
                if (load[i]) slot_q[i] <= ts_value;
            end
        end
    end

    assign t1 = slot_q[0];
    assign t2 = slot_q[1];
    assign t3 = slot_q[2];

endmodule

// File: rtl/ptp_sync_math.sv
module ptp_sync_math #(
    parameter int unsigned TS_W = 64
) (
    input  logic [TS_W-1:0] t1,
    input  logic [TS_W-1:0] t2,
    input  logic [TS_W-1:0] t3,
    input  logic [TS_W-1:0] t4,
    output logic [TS_W-1:0] offset_calc,
    output logic [TS_W-1:0] delay_calc,
    output logic            delay_neg
);

    // Two guard bits: one for each difference, one for their sum.
    localparam int unsigned GUARD = 2;
    localparam int unsigned WIDE  = TS_W + GUARD;

    logic signed [WIDE-1:0] t1_w, t2_w, t3_w, t4_w;
    logic signed [WIDE-1:0] fwd, rev, sum_w, dif_w;
    logic signed [WIDE-1:0] half_sum, half_dif;

    always_comb begin
        t1_w     = $signed({{GUARD{t1[TS_W-1]}}, t1});
        t2_w     = $signed({{GUARD{t2[TS_W-1]}}, t2});
        t3_w     = $signed({{GUARD{t3[TS_W-1]}}, t3});
        t4_w     = $signed({{GUARD{t4[TS_W-1]}}, t4});
        fwd      = t2_w - t1_w;
        rev      = t4_w - t3_w;
        sum_w    = fwd + rev;
        dif_w    = fwd - rev;
        half_sum = sum_w >>> 1;
        half_dif = dif_w >>> 1;
    end

    assign delay_calc  = half_sum[TS_W-1:0];
    assign offset_calc = half_dif[TS_W-1:0];
    assign delay_neg   = half_sum[WIDE-1];

endmodule

// File: rtl/ptp_offset_delay_calc.sv
module ptp_offset_delay_calc
    import ptp_calc_pkg::*;
#(
    parameter int unsigned TS_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ts_valid,
    input  logic [1:0]      ts_tag,
    input  logic [TS_W-1:0] ts_value,
    output logic            done,
    output logic [TS_W-1:0] offset,
    output logic [TS_W-1:0] mean_delay,
    output logic            delay_err
);

    logic [HELD_TS-1:0] load;
    logic               fire;
    logic [TS_W-1:0]    t1, t2, t3;
    logic [TS_W-1:0]    offset_calc, delay_calc;
    logic               delay_neg;

    ptp_calc_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ts_valid (ts_valid),
        .ts_tag   (ts_tag),
        .load     (load),
        .fire     (fire)
    );

    ptp_ts_store #(.TS_W(TS_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .ts_value (ts_value),
        .t1       (t1),
        .t2       (t2),
        .t3       (t3)
    );

    // The fourth timestamp feeds the arithmetic straight from the input.
    ptp_sync_math #(.TS_W(TS_W)) u_math (
        .t1          (t1),
        .t2          (t2),
        .t3          (t3),
        .t4          (ts_value),
        .offset_calc (offset_calc),
        .delay_calc  (delay_calc),
        .delay_neg   (delay_neg)
    );

    // Output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            offset     <= '0;
            mean_delay <= '0;
            delay_err  <= 1'b0;
        end else begin
            done <= fire;
            if (fire) begin
                mean_delay <= delay_calc;
                delay_err  <= delay_neg;
                if (!delay_neg) offset <= offset_calc;
            end
        end
    end

endmodule

// File: rtl/ptp_calc_chk.sv
module ptp_calc_chk #(
    parameter int unsigned TS_W = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ts_valid,
    input logic [1:0]      ts_tag,
    input logic            done,
    input logic [TS_W-1:0] offset,
    input logic [TS_W-1:0] mean_delay,
    input logic            delay_err
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!done && !delay_err && offset == '0 && mean_delay == '0));

    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(ts_valid && ts_tag == 2'd3));

    p_err_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (delay_err == mean_delay[TS_W-1]));

    p_offset_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && delay_err) |-> $stable(offset));

    p_hold_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(offset) && $stable(mean_delay) && $stable(delay_err)));

endmodule

bind ptp_offset_delay_calc ptp_calc_chk #(.TS_W(TS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ts_valid   (ts_valid),
    .ts_tag     (ts_tag),
    .done       (done),
    .offset     (offset),
    .mean_delay (mean_delay),
    .delay_err  (delay_err)
);

// File: tb/ptp_offset_delay_calc_tb_top.sv
module ptp_offset_delay_calc_tb_top;

    localparam int unsigned TS_W = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ts_valid = 1'b0;
    logic [1:0]      ts_tag = 2'd0;
    logic [TS_W-1:0] ts_value = '0;
    logic            done;
    logic [TS_W-1:0] offset;
    logic [TS_W-1:0] mean_delay;
    logic            delay_err;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    longint last_offset = 0;

    always #2 clk = ~clk;   // 250 MHz

    ptp_offset_delay_calc #(.TS_W(TS_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ts_valid   (ts_valid),
        .ts_tag     (ts_tag),
        .ts_value   (ts_value),
        .done       (done),
        .offset     (offset),
        .mean_delay (mean_delay),
        .delay_err  (delay_err)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one valid timestamp for a single cycle; returns at the next falling edge.
    task automatic send(input logic [1:0] tag, input longint val);
        @(negedge clk);
        ts_valid = 1'b1;
        ts_tag   = tag;
        ts_value = val;
        @(negedge clk);
        ts_valid = 1'b0;
        ts_value = '0;
    endtask

    function automatic longint floor_half(input longint x);
        return x >>> 1;
    endfunction

    // Full exchange; checks results at the done cycle and silence afterwards.
    task automatic exchange(input string tname, input longint a, input longint b,
                            input longint c, input longint d);
        longint fwd, rev, e_delay, e_off;
        fwd     = b - a;
        rev     = d - c;
        e_delay = floor_half(fwd + rev);
        e_off   = floor_half(fwd - rev);
        send(2'd0, a);
        send(2'd1, b);
        send(2'd2, c);
        chk("R3", {tname, " done before t4"}, longint'(done), 0);
        send(2'd3, d);
        chk("R3", {tname, " done after t4"}, longint'(done), 1);
        chk("R4", {tname, " mean delay"}, longint'(mean_delay), e_delay);
        if (e_delay < 0) begin
            chk("R7", {tname, " error flag"}, longint'(delay_err), 1);
            chk("R7", {tname, " offset held"}, longint'(offset), last_offset);
        end else begin
            chk("R7", {tname, " error flag clear"}, longint'(delay_err), 0);
            chk("R5", {tname, " offset"}, longint'(offset), e_off);
            last_offset = e_off;
        end
        @(negedge clk);
        chk("R3", {tname, " done one cycle"}, longint'(done), 0);
        chk("R8", {tname, " delay held"}, longint'(mean_delay), e_delay);
        chk("R8", {tname, " offset held"}, longint'(offset), last_offset);
    endtask

    task automatic test_reset();
        chk("R1", "done in reset", longint'(done), 0);
        chk("R1", "offset in reset", longint'(offset), 0);
        chk("R1", "delay in reset", longint'(mean_delay), 0);
        chk("R1", "err in reset", longint'(delay_err), 0);
    endtask

    task automatic test_basic();
        exchange("basic", 1000, 1507, 2000, 2493);            // delay 500, offset 7
    endtask

    task automatic test_rounding();
        exchange("neg odd offset", 0, 10, 20, 33);             // offset -2, delay 11
        exchange("pos odd", 0, 9, 20, 24);                     // delay 6, offset 2
    endtask

    task automatic test_epoch();
        longint base = 64'sd1234567890123456789;
        exchange("epoch", base, base + 250123, base + 1250123, base + 1500000);
    endtask

    task automatic test_restart();
        send(2'd0, 100);
        send(2'd1, 200);
        send(2'd2, 300);
        send(2'd0, 5000);   // R6: restart with a new t1
        chk("R6", "no done on restart", longint'(done), 0);
        exchange("R6 restart tail", 5000, 5050, 6000, 6030);
        send(2'd0, 1);
        send(2'd1, 900);
        send(2'd0, 7000);   // R6: restart from the t3 wait
        exchange("R6 second", 7000, 7100, 7200, 7260);
    endtask

    task automatic test_ignore();
        send(2'd0, 10000);
        send(2'd2, 99999);   // R2: t3 while t2 expected
        send(2'd3, 88888);   // R2: t4 while t2 expected
        chk("R2", "no done on stray t4", longint'(done), 0);
        send(2'd1, 10040);
        send(2'd1, 77777);   // R2: repeat t2 ignored
        send(2'd3, 66666);   // R2: t4 while t3 expected
        chk("R2", "no done on early t4", longint'(done), 0);
        // R9: garbage with valid low
        @(negedge clk);
        ts_valid = 1'b0; ts_tag = 2'd0; ts_value = 64'd55555;
        @(negedge clk);
        ts_tag = 2'd3;
        @(negedge clk);
        chk("R9", "no done with valid low", longint'(done), 0);
        send(2'd2, 11000);
        send(2'd3, 11020);   // fwd 40, rev 20: delay 30, offset 10
        chk("R2", "done after ordered set", longint'(done), 1);
        chk("R2", "delay ignores strays", longint'(mean_delay), 30);
        chk("R9", "offset ignores idle garbage", longint'(offset), 10);
        last_offset = 10;
    endtask

    task automatic test_negative();
        exchange("R7 negative", 0, 5, 100, 90);               // delay -3
        exchange("R7 recover", 0, 60, 100, 140);              // delay 50, offset 10
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_basic();
        test_rounding();
        test_epoch();
        test_restart();
        test_ignore();
        test_negative();
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule